// File: doc/BRIEF.md
# SDRAM Command Decoder and Sequencing Checker

This block sits beside an SDRAM controller and watches the memory control pins on every rising clock edge. Each cycle it turns chip select, the three strobe lines, the clock-enable history, the bank address and the A10 line into one command. It also reports the bank the command targets and whether a precharge covers every bank.

While decoding, it keeps a view of the device for each of four banks: which rows are open, whether an auto-precharge burst is still running, and how much of the precharge recovery time is left. It also tracks the wait that follows a mode-register write. A command that breaks one of these sequencing rules is reported with a violation flag and a code giving the reason. A command that is flagged is treated as never issued, so it does not change the tracked state.

Outputs are registered. The result for pins sampled at edge N appears just after edge N. The burst length, the recovery time tRP, the mode-register wait and the number of banks are parameters. Their defaults are 4, 2, 2 and 4.

Top module: `sdcmd_monitor`

## Requirements
- R1: During reset and on the first edge after reset, the outputs show command code 0 (deselect), bank 0, no all-banks flag, no violation flag and violation code 0. After reset all banks are idle and no counter is running.
- R2: With chip select high the command code is 0 (deselect). With chip select low and the previous clock enable high, RAS/CAS/WE decode as follows: 111 is 1 (no operation), 000 is 2 (mode register write), 011 is 5 (activate), 101 is 6 (read), 100 is 7 (write), 110 is 8 (burst stop) and 010 is 9 (precharge). Codes 0 and 1 are never flagged.
- R3: For activate, read, write and single-bank precharge, the bank output equals the two bank-address bits. A precharge with A10 high raises the all-banks flag, drives bank 0, and closes every bank whatever the bank address.
- R4: A mode register write while any bank is open is flagged with code 1.
- R5: After an accepted mode register write, any command other than codes 0 and 1 on either of the next two edges is flagged with code 2.
- R6: Pattern 001 decodes as code 3 (auto refresh) when the current clock enable is high, and as code 4 (self-refresh entry) when it is low. Either one is flagged with code 3 while any bank is open.
- R7: A read or write to a bank that is not open is flagged with code 6. Activate opens a bank, and precharge closes it.
- R8: A read or write with A10 high starts an auto-precharge burst that lasts the burst length. Any read or write on the edges that follow, up to the burst length minus one, is flagged with code 4, whatever its bank. A read or write to another open bank is accepted from the burst length onward.
- R9: The bank of an auto-precharge burst closes on the last edge of the burst. An activate of that bank is flagged with code 5 until tRP edges have passed after that last edge. With the defaults, this is legal from the sixth edge after the read or write.
- R10: Burst stop is never flagged, except during the mode-register wait. During an auto-precharge burst it ends the burst on that edge: the bank closes and its tRP wait starts at once.
- R11: A flagged command has no effect. A flagged activate leaves its bank closed.
- R12: While the previous clock enable is low and chip select is low, every pin pattern decodes as code 1, and nothing is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; pins sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke_prev | input | 1 | Clock enable sampled on the previous edge |
| cke | input | 1 | Clock enable on this edge |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Auto-precharge / all-banks select line |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | BA_W | Target bank index |
| all_banks_o | output | 1 | Precharge applies to all banks |
| viol_o | output | 1 | Sequencing violation this cycle |
| viol_code_o | output | 3 | Reason for the violation, 0 when none |

## Verification
Two events can share an edge.
- **Burst end and tRP start.** The end of an auto-precharge burst closes its bank and starts the tRP count on the same edge that another command arrives.
- **Burst stop during a burst.** A burst stop issued partway through a burst does the same work early.

The bench targets both. It issues a read to another bank on the exact edge the burst ends, which must still be flagged as a conflict. It then issues a burst stop one edge into a burst, and follows it with an activate of the closing bank and a write to an idle bank. The codes returned show whether the close, the recovery count and the end of the burst all took effect on the intended edge.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL = 4'd0,
        CMD_NOP   = 4'd1,
        CMD_MRS   = 4'd2,
        CMD_REF   = 4'd3,
        CMD_SREF  = 4'd4,
        CMD_ACT   = 4'd5,
        CMD_RD    = 4'd6,
        CMD_WR    = 4'd7,
        CMD_BST   = 4'd8,
        CMD_PRE   = 4'd9
    } cmd_e;

    typedef enum logic [2:0] {
        V_NONE      = 3'd0,
        V_MRS_BUSY  = 3'd1,
        V_MRS_WAIT  = 3'd2,
        V_REF_BUSY  = 3'd3,
        V_AP_CONF   = 3'd4,
        V_TRP       = 3'd5,
        V_IDLE_ACC  = 3'd6
    } viol_e;

    typedef struct packed {
        cmd_e cmd;
        logic all_banks;
        logic auto_pre;
    } dec_t;

    function automatic cmd_e decode_pins(input logic cs_n, input logic ras_n,
                                         input logic cas_n, input logic we_n,
                                         input logic ck_prev, input logic ck);
        cmd_e c;
        if (cs_n)
            c = CMD_DESEL;
        else if (!ck_prev)
            c = CMD_NOP;
        else begin
            case ({ras_n, cas_n, we_n})
                3'b000:  c = CMD_MRS;
                3'b001:  c = ck ? CMD_REF : CMD_SREF;
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_RD;
                3'b100:  c = CMD_WR;
                3'b110:  c = CMD_BST;
                3'b010:  c = CMD_PRE;
                default: c = CMD_NOP;
            endcase
        end
        return c;
    endfunction

    function automatic logic is_rdwr(input cmd_e c);
        return (c == CMD_RD) || (c == CMD_WR);
    endfunction

    function automatic logic is_live(input cmd_e c);
        return (c != CMD_DESEL) && (c != CMD_NOP);
    endfunction

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
    import sdcmd_pkg::*;
#(
    parameter int BA_W = 2
) (
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic            cke_prev,
    input  logic            cke,
    input  logic [BA_W-1:0] ba,
    input  logic            a10,
    output dec_t            dec_o,
    output logic [BA_W-1:0] bank_o
);
    cmd_e c;
    logic banked;

    always_comb begin
        c               = decode_pins(cs_n, ras_n, cas_n, we_n, cke_prev, cke);
        dec_o.cmd       = c;
        dec_o.all_banks = (c == CMD_PRE) && a10;
        dec_o.auto_pre  = is_rdwr(c) && a10;
        banked          = (c == CMD_ACT) || is_rdwr(c) || ((c == CMD_PRE) && !a10);
        bank_o          = banked ? ba : '0;
    end
endmodule

// File: rtl/sdcmd_bank.sv
module sdcmd_bank #(
    parameter int T_RP = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic open_i,
    input  logic close_i,
    input  logic trp_start_i,
    output logic active_o,
    output logic trp_busy_o
);
    localparam int TW = $clog2(T_RP + 2);
    localparam logic [TW-1:0] TRP_LOAD = TW'(T_RP);

    logic [TW-1:0] trp_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_o <= 1'b0;
            trp_cnt  <= '0;
        end else begin
            if (close_i)
                active_o <= 1'b0;
            else if (open_i)
                active_o <= 1'b1;

            if (trp_start_i)
                trp_cnt <= TRP_LOAD;
            else if (trp_cnt != '0)
                trp_cnt <= trp_cnt - 1'b1;
        end
    end

    assign trp_busy_o = (trp_cnt != '0);
endmodule

// File: rtl/sdcmd_rules.sv
module sdcmd_rules
    import sdcmd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BURST_LEN = 4,
    parameter int MRS_WAIT  = 2,
    parameter int BA_W      = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  dec_t                 dec_i,
    input  logic [BA_W-1:0]      bank_i,
    input  logic [NUM_BANKS-1:0] bank_active_i,
    input  logic [NUM_BANKS-1:0] bank_trp_i,
    output viol_e                code_o,
    output logic [NUM_BANKS-1:0] open_o,
    output logic [NUM_BANKS-1:0] close_o,
    output logic [NUM_BANKS-1:0] trp_start_o
);
    localparam int MW = $clog2(MRS_WAIT + 2);
    localparam int AW = $clog2(BURST_LEN + 2);
    localparam logic [MW-1:0] MRS_LOAD = MW'(MRS_WAIT);
    localparam logic [AW-1:0] AP_LOAD  = AW'(BURST_LEN - 1);
    localparam logic [AW-1:0] AP_LAST  = AW'(1);
    localparam bit MULTI_BEAT = (BURST_LEN > 1);

    logic [MW-1:0]   mrs_cnt;
    logic [AW-1:0]   ap_cnt;
    logic [BA_W-1:0] ap_bank;
    logic            mrs_busy, ap_run, any_active, ok;
    logic            ap_issue, bst_ok;

    assign mrs_busy   = (mrs_cnt != '0);
    assign ap_run     = (ap_cnt != '0);
    assign any_active = |bank_active_i;

    always_comb begin
        code_o = V_NONE;
        if (mrs_busy && is_live(dec_i.cmd))
            code_o = V_MRS_WAIT;
        else begin
            case (dec_i.cmd)
                CMD_MRS:
                    if (any_active) code_o = V_MRS_BUSY;
                CMD_REF, CMD_SREF:
                    if (any_active) code_o = V_REF_BUSY;
                CMD_RD, CMD_WR:
                    if (ap_run)
                        code_o = V_AP_CONF;
                    else if (!bank_active_i[bank_i])
                        code_o = V_IDLE_ACC;
                CMD_ACT:
                    if (bank_trp_i[bank_i]) code_o = V_TRP;
                default: ;
            endcase
        end
    end

    assign ok       = (code_o == V_NONE);
    assign ap_issue = ok && dec_i.auto_pre;
    assign bst_ok   = ok && (dec_i.cmd == CMD_BST);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_ctl
        logic sel, pre_hit, ap_end, ap_now;
        assign sel     = (bank_i == BA_W'(b));
        assign pre_hit = ok && (dec_i.cmd == CMD_PRE) && (dec_i.all_banks || sel);
        assign ap_end  = ap_run && (ap_bank == BA_W'(b)) && ((ap_cnt == AP_LAST) || bst_ok);
        assign ap_now  = !MULTI_BEAT && ap_issue && sel;
        assign open_o[b]      = ok && (dec_i.cmd == CMD_ACT) && sel;
        assign trp_start_o[b] = ap_end || ap_now;
        assign close_o[b]     = pre_hit || ap_end || ap_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mrs_cnt <= '0;
            ap_cnt  <= '0;
            ap_bank <= '0;
        end else begin
            if (ok && (dec_i.cmd == CMD_MRS))
                mrs_cnt <= MRS_LOAD;
            else if (mrs_busy)
                mrs_cnt <= mrs_cnt - 1'b1;

            if (ap_issue && MULTI_BEAT) begin
                ap_cnt  <= AP_LOAD;
                ap_bank <= bank_i;
            end else if (bst_ok)
                ap_cnt <= '0;
            else if (ap_run)
                ap_cnt <= ap_cnt - 1'b1;
        end
    end
endmodule

// File: rtl/sdcmd_monitor.sv
module sdcmd_monitor
    import sdcmd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BURST_LEN = 4,
    parameter int T_RP      = 2,
    parameter int MRS_WAIT  = 2,
    parameter int BA_W      = $clog2(NUM_BANKS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic            cke_prev,
    input  logic            cke,
    input  logic [BA_W-1:0] ba,
    input  logic            a10,
    output logic [3:0]      cmd_o,
    output logic [BA_W-1:0] bank_o,
    output logic            all_banks_o,
    output logic            viol_o,
    output logic [2:0]      viol_code_o
);
    dec_t                 dec;
    logic [BA_W-1:0]      dec_bank;
    viol_e                code;
    logic [NUM_BANKS-1:0] bank_active, bank_trp, open_req, close_req, trp_req;

    sdcmd_decode #(.BA_W(BA_W)) u_decode (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cke_prev(cke_prev), .cke(cke), .ba(ba), .a10(a10),
        .dec_o(dec), .bank_o(dec_bank)
    );

    sdcmd_rules #(
        .NUM_BANKS(NUM_BANKS), .BURST_LEN(BURST_LEN),
        .MRS_WAIT(MRS_WAIT), .BA_W(BA_W)
    ) u_rules (
        .clk(clk), .rst(rst), .dec_i(dec), .bank_i(dec_bank),
        .bank_active_i(bank_active), .bank_trp_i(bank_trp),
        .code_o(code), .open_o(open_req), .close_o(close_req),
        .trp_start_o(trp_req)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdcmd_bank #(.T_RP(T_RP)) u_bank (
            .clk(clk), .rst(rst),
            .open_i(open_req[b]), .close_i(close_req[b]),
            .trp_start_i(trp_req[b]),
            .active_o(bank_active[b]), .trp_busy_o(bank_trp[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_o       <= CMD_DESEL;
            bank_o      <= '0;
            all_banks_o <= 1'b0;
            viol_o      <= 1'b0;
            viol_code_o <= V_NONE;
        end else begin
            cmd_o       <= dec.cmd;
            bank_o      <= dec_bank;
            all_banks_o <= dec.all_banks;
            viol_o      <= (code != V_NONE);
            viol_code_o <= code;
        end
    end
endmodule

// File: rtl/sdcmd_monitor_chk.sv
module sdcmd_monitor_chk #(
    parameter int BA_W = 2
) (
    input logic            clk,
    input logic            rst,
    input logic [3:0]      cmd_o,
    input logic [BA_W-1:0] bank_o,
    input logic            all_banks_o,
    input logic            viol_o,
    input logic [2:0]      viol_code_o
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (cmd_o == 4'd0 && !viol_o && viol_code_o == 3'd0)); // R1

    AST_IDLE_NEVER_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (cmd_o <= 4'd1) |-> !viol_o); // R2

    AST_ALL_BANKS_ON_PRE: assert property (@(posedge clk) disable iff (rst)
        all_banks_o |-> (cmd_o == 4'd9 && bank_o == '0)); // R3

    AST_MRS_HOLDOFF: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == 4'd2 && !viol_o) |=> (cmd_o <= 4'd1 || viol_code_o == 3'd2)); // R5

    AST_IDLE_ACCESS_RW: assert property (@(posedge clk) disable iff (rst)
        (viol_code_o == 3'd6) |-> (cmd_o == 4'd6 || cmd_o == 4'd7)); // R7

    AST_TRP_ON_ACT: assert property (@(posedge clk) disable iff (rst)
        (viol_code_o == 3'd5) |-> (cmd_o == 4'd5)); // R9

    AST_BST_ALWAYS_OK: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == 4'd8) |-> (viol_code_o == 3'd0 || viol_code_o == 3'd2)); // R10
endmodule

bind sdcmd_monitor sdcmd_monitor_chk #(.BA_W(BA_W)) u_chk (
    .clk(clk), .rst(rst), .cmd_o(cmd_o), .bank_o(bank_o),
    .all_banks_o(all_banks_o), .viol_o(viol_o), .viol_code_o(viol_code_o)
);

// File: tb/sdcmd_monitor_bench.sv
`timescale 1ns/1ps
module sdcmd_monitor_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic       cke_prev = 1'b1, cke = 1'b1;
    logic [1:0] ba = 2'd0;
    logic       a10 = 1'b0;
    logic [3:0] cmd_o;
    logic [1:0] bank_o;
    logic       all_banks_o, viol_o;
    logic [2:0] viol_code_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sdcmd_monitor u_sdcmd_monitor (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke_prev(cke_prev), .cke(cke), .ba(ba), .a10(a10),
        .cmd_o(cmd_o), .bank_o(bank_o), .all_banks_o(all_banks_o),
        .viol_o(viol_o), .viol_code_o(viol_code_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive one command at the falling edge; results registered on the next rising edge.
    task automatic issue(input int kind, input logic [1:0] b, input logic ap,
                         input logic ckp, input logic ck);
        @(negedge clk);
        cs_n = (kind == 0);
        case (kind)
            2:       {ras_n, cas_n, we_n} = 3'b000;
            3, 4:    {ras_n, cas_n, we_n} = 3'b001;
            5:       {ras_n, cas_n, we_n} = 3'b011;
            6:       {ras_n, cas_n, we_n} = 3'b101;
            7:       {ras_n, cas_n, we_n} = 3'b100;
            8:       {ras_n, cas_n, we_n} = 3'b110;
            9:       {ras_n, cas_n, we_n} = 3'b010;
            default: {ras_n, cas_n, we_n} = 3'b111;
        endcase
        ba = b; a10 = ap; cke_prev = ckp; cke = ck;
        @(posedge clk);
        #2;
    endtask

    task automatic cmd_chk(input string tag, input int kind, input logic [1:0] b,
                           input logic ap, input int exp_code);
        issue(kind, b, ap, 1'b1, (kind != 4));
        check({tag, " cmd"}, cmd_o, kind);
        check({tag, " code"}, viol_code_o, exp_code);
        check({tag, " flag"}, viol_o, exp_code != 0);
    endtask

    task automatic settle();
        issue(9, 2'd0, 1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 6; i++) issue(1, 2'd0, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_reset();
        check("R1 cmd", cmd_o, 0);
        check("R1 flag", viol_o, 0);
        check("R1 code", viol_code_o, 0);
        check("R1 all", all_banks_o, 0);
        check("R1 bank", bank_o, 0);
    endtask

    task automatic t_decode();
        cmd_chk("R2 nop", 1, 2'd0, 1'b0, 0);
        cmd_chk("R2 desel", 0, 2'd0, 1'b0, 0);
        cmd_chk("R10 bst idle", 8, 2'd0, 1'b0, 0);
        cmd_chk("R6 ref idle", 3, 2'd0, 1'b0, 0);
        settle();
    endtask

    task automatic t_bank();
        cmd_chk("R3 act", 5, 2'd2, 1'b0, 0);
        check("R3 act bank", bank_o, 2);
        cmd_chk("R3 wr", 7, 2'd2, 1'b0, 0);
        check("R3 wr bank", bank_o, 2);
        check("R3 wr all", all_banks_o, 0);
        cmd_chk("R3 pre all", 9, 2'd3, 1'b1, 0);
        check("R3 pre all flag", all_banks_o, 1);
        check("R3 pre all bank", bank_o, 0);
        cmd_chk("R7 rd closed", 6, 2'd2, 1'b0, 6);
        settle();
    endtask

    task automatic t_mrs();
        cmd_chk("R4 act", 5, 2'd1, 1'b0, 0);
        cmd_chk("R4 mrs open", 2, 2'd0, 1'b0, 1);
        cmd_chk("R3 pre one", 9, 2'd1, 1'b0, 0);
        check("R3 pre one bank", bank_o, 1);
        check("R3 pre one all", all_banks_o, 0);
        cmd_chk("R4 mrs idle", 2, 2'd0, 1'b0, 0);
        cmd_chk("R5 wait1", 5, 2'd2, 1'b0, 2);
        cmd_chk("R5 wait2", 8, 2'd0, 1'b0, 2);
        cmd_chk("R5 after", 5, 2'd0, 1'b0, 0);
        cmd_chk("R11 rejected act", 6, 2'd2, 1'b0, 6);
        settle();
    endtask

    task automatic t_ref();
        cmd_chk("R6 act", 5, 2'd3, 1'b0, 0);
        cmd_chk("R6 ref open", 3, 2'd0, 1'b0, 3);
        cmd_chk("R6 sref open", 4, 2'd0, 1'b0, 3);
        issue(9, 2'd0, 1'b1, 1'b1, 1'b1);
        cmd_chk("R6 sref idle", 4, 2'd0, 1'b0, 0);
        issue(5, 2'd1, 1'b0, 1'b0, 1'b0);
        check("R12 suspended cmd", cmd_o, 1);
        check("R12 suspended flag", viol_o, 0);
        issue(2, 2'd0, 1'b0, 1'b0, 1'b1);
        check("R12 exit cmd", cmd_o, 1);
        check("R12 exit flag", viol_o, 0);
        settle();
    endtask

    task automatic t_autopre();
        cmd_chk("R8 act0", 5, 2'd0, 1'b0, 0);
        cmd_chk("R8 act1", 5, 2'd1, 1'b0, 0);
        cmd_chk("R8 rd ap", 6, 2'd0, 1'b1, 0);
        cmd_chk("R8 wr other", 7, 2'd1, 1'b0, 4);
        cmd_chk("R8 rd other", 6, 2'd1, 1'b0, 4);
        cmd_chk("R8 rd at end", 6, 2'd1, 1'b0, 4);
        cmd_chk("R9 act early", 5, 2'd0, 1'b0, 5);
        cmd_chk("R8 rd after", 6, 2'd1, 1'b0, 0);
        cmd_chk("R9 act legal", 5, 2'd0, 1'b0, 0);
        settle();
    endtask

    task automatic t_bst();
        cmd_chk("R10 act", 5, 2'd2, 1'b0, 0);
        cmd_chk("R10 rd ap", 6, 2'd2, 1'b1, 0);
        cmd_chk("R10 bst in burst", 8, 2'd0, 1'b0, 0);
        cmd_chk("R10 act trp", 5, 2'd2, 1'b0, 5);
        cmd_chk("R10 wr idle", 7, 2'd0, 1'b0, 6);
        cmd_chk("R10 act later", 5, 2'd2, 1'b0, 0);
        settle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        t_reset();
        t_decode();
        t_bank();
        t_mrs();
        t_ref();
        t_autopre();
        t_bst();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule